// File: doc/BRIEF.md
# Branch Checkpoint Register Map

This block holds the speculative register map of an out-of-order core: one data word and one ready bit for each architectural register. Alongside the live map it keeps a small pool of snapshots, one per unresolved branch. A decoded branch takes a free snapshot slot, which is filled with the map as it stands after that cycle's updates. The slot is tagged with the branch's sequence number.

Results arriving from execution write the live map. They also patch every held snapshot whose branch is younger than the producing instruction, so each snapshot always reflects the completed work that precedes its branch. When a branch turns out to be mispredicted, its snapshot is copied back into the live map in a single cycle, and the snapshots of all younger branches are released. The instruction on the correct path can then read a correct map in the very next cycle, without waiting for the machine to drain. A branch that resolves correctly simply gives its slot back.

Sequence numbers wrap around, so age is judged by the sign of their modular difference. Decode of a new branch is held off through a ready/valid handshake whenever the pool is full or a resolve is being presented.

Top module: `regmap_ckpt`

## Requirements
- R1: After reset every register reads data 0 with its ready bit set, and every slot is free: `dec_ready` is 1 and `dec_slot` is 0.
- R2: A writeback sets the target register's data and ready bit in the live map. The new value is visible through the read port one cycle after the writeback edge.
- R3: A claim (`ren_valid`) clears the ready bit of its register in the live map and leaves the data unchanged. A claim presented in a restore cycle is ignored.
- R4: A branch accepted when `dec_valid` and `dec_ready` are both high takes the lowest-numbered free slot, which is shown on `dec_slot` before the edge. The slot captures the live map including that cycle's writeback and claim.
- R5: A writeback whose sequence number is older than a held slot's branch is also written into that slot.
- R6: A writeback that is not older than a slot's branch leaves that slot untouched. A mispredict restore of the slot therefore returns the pre-writeback value.
- R7: `dec_ready` is low when all slots are held or while `res_valid` is high.
- R8: A mispredict on a held slot copies that slot into the live map and frees both that slot and every held slot whose branch is younger.
- R9: A correct resolve (`res_mispredict` = 0) frees only its own slot and leaves the live map unchanged.
- R10: When a writeback and a mispredict restore arrive in the same cycle, the restore wins. A writeback younger than the mispredicted branch is discarded. An older one is applied on top of the restored map.
- R11: Age is decided by treating the 8-bit difference (a − b) as a signed number: a is younger than b when that signed value is positive. This stays correct across wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Branch decode request |
| dec_seq | input | SW | Sequence number of the decoded branch |
| dec_ready | output | 1 | A slot can be taken this cycle |
| dec_slot | output | CW | Slot that the branch will take |
| ren_valid | input | 1 | Destination claim: clear the register's ready bit |
| ren_reg | input | RW | Register being claimed |
| wb_valid | input | 1 | Result writeback |
| wb_seq | input | SW | Sequence number of the producing instruction |
| wb_reg | input | RW | Destination register |
| wb_data | input | DW | Result value |
| res_valid | input | 1 | Branch resolution |
| res_slot | input | CW | Slot of the resolving branch |
| res_mispredict | input | 1 | 1 = mispredicted, restore; 0 = correct, release only |
| rd_reg | input | RW | Register to read from the live map |
| rd_data | output | DW | Registered read data |
| rd_vld | output | 1 | Registered ready bit |

## Verification
`dec_ready` and `dec_slot` are combinational views of registered slot state. The bench checks them after driving inputs at the falling edge and before the rising edge that accepts the branch. Map updates land at the rising edge. The read port registers the map one edge later, so a read is driven at the falling edge after the update and compared 1 ns after the next rising edge. Slot state is observed only through `dec_slot` and through reads taken after a restore, because a mispredict is the only way a snapshot reaches the ports.

// File: rtl/regmap_ckpt_pkg.sv
package regmap_ckpt_pkg;

  // a is younger than b when the modular difference is positive in w bits
  function automatic logic seq_younger(input logic [31:0] a, input logic [31:0] b,
                                       input int unsigned w);
    logic [31:0] d;
    d = (a - b) << (32 - w);
    return $signed(d) > 0;
  endfunction

  typedef enum logic [1:0] {
    RES_IDLE    = 2'd0,
    RES_RELEASE = 2'd1,
    RES_RESTORE = 2'd2
  } res_kind_e;

endpackage

// File: rtl/regmap_live.sv
module regmap_live #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      restore_en,
  input  logic [NREG-1:0][DW-1:0]   restore_val,
  input  logic [NREG-1:0]           restore_vld,
  input  logic                      wb_en,
  input  logic [RW-1:0]             wb_reg,
  input  logic [DW-1:0]             wb_data,
  input  logic                      claim_en,
  input  logic [RW-1:0]             claim_reg,
  input  logic [RW-1:0]             rd_reg,
  output logic [DW-1:0]             rd_data,
  output logic                      rd_vld,
  output logic [NREG-1:0][DW-1:0]   nxt_val,
  output logic [NREG-1:0]           nxt_vld
);

  logic [NREG-1:0][DW-1:0] val_q;
  logic [NREG-1:0]         vld_q;

  always_comb begin
    nxt_val = restore_en ? restore_val : val_q;
    nxt_vld = restore_en ? restore_vld : vld_q;
    if (wb_en) begin
      nxt_val[wb_reg] = wb_data;
      nxt_vld[wb_reg] = 1'b1;
    end
    if (claim_en && !restore_en) begin
      nxt_vld[claim_reg] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= '0;
      vld_q   <= '1;
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      val_q   <= nxt_val;
      vld_q   <= nxt_vld;
      rd_data <= val_q[rd_reg];
      rd_vld  <= vld_q[rd_reg];
    end
  end

endmodule

// File: rtl/regmap_slot.sv
module regmap_slot
  import regmap_ckpt_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int SW   = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc,
  input  logic [SW-1:0]             alloc_seq,
  input  logic [NREG-1:0][DW-1:0]   cap_val,
  input  logic [NREG-1:0]           cap_vld,
  input  logic                      release_en,
  input  logic                      wb_en,
  input  logic [SW-1:0]             wb_seq,
  input  logic [RW-1:0]             wb_reg,
  input  logic [DW-1:0]             wb_data,
  output logic                      busy,
  output logic [SW-1:0]             seq,
  output logic [NREG-1:0][DW-1:0]   val,
  output logic [NREG-1:0]           vld
);

  logic patch;
  assign patch = busy && wb_en && seq_younger(32'(seq), 32'(wb_seq), SW);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      seq  <= '0;
      val  <= '0;
      vld  <= '1;
    end else if (alloc) begin
      busy <= 1'b1;
      seq  <= alloc_seq;
      val  <= cap_val;
      vld  <= cap_vld;
    end else begin
      if (release_en) busy <= 1'b0;
      if (patch) begin
        val[wb_reg] <= wb_data;
        vld[wb_reg] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/regmap_pick.sv
module regmap_pick #(
  parameter int NCK  = 4,
  localparam int CW  = $clog2(NCK)
) (
  input  logic [NCK-1:0] busy,
  output logic           any_free,
  output logic [CW-1:0]  first_free
);

  always_comb begin
    first_free = '0;
    for (int i = NCK - 1; i >= 0; i--) begin
      if (!busy[i]) first_free = CW'(i);
    end
  end

  assign any_free = ~&busy;

endmodule

// File: rtl/regmap_ckpt.sv
module regmap_ckpt
  import regmap_ckpt_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int NCK  = 4,
  parameter int SW   = 8,
  localparam int RW  = $clog2(NREG),
  localparam int CW  = $clog2(NCK)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [SW-1:0] dec_seq,
  output logic          dec_ready,
  output logic [CW-1:0] dec_slot,
  input  logic          ren_valid,
  input  logic [RW-1:0] ren_reg,
  input  logic          wb_valid,
  input  logic [SW-1:0] wb_seq,
  input  logic [RW-1:0] wb_reg,
  input  logic [DW-1:0] wb_data,
  input  logic          res_valid,
  input  logic [CW-1:0] res_slot,
  input  logic          res_mispredict,
  input  logic [RW-1:0] rd_reg,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);

  logic [NCK-1:0]                     busy_q;
  logic [NCK-1:0][SW-1:0]             ck_seq;
  logic [NCK-1:0][NREG-1:0][DW-1:0]   ck_val;
  logic [NCK-1:0][NREG-1:0]           ck_vld;
  logic [NREG-1:0][DW-1:0]            nxt_val;
  logic [NREG-1:0]                    nxt_vld;
  logic                               any_free;
  logic [CW-1:0]                      first_free;
  res_kind_e                          res_kind;
  logic [SW-1:0]                      res_seq;
  logic                               wb_en;
  logic                               dec_fire;

  regmap_pick #(.NCK(NCK)) u_pick (
    .busy       (busy_q),
    .any_free   (any_free),
    .first_free (first_free)
  );

  assign dec_ready = any_free && !res_valid;
  assign dec_slot  = first_free;
  assign dec_fire  = dec_valid && dec_ready;
  assign res_seq   = ck_seq[res_slot];

  always_comb begin
    res_kind = RES_IDLE;
    if (res_valid && busy_q[res_slot])
      res_kind = res_mispredict ? RES_RESTORE : RES_RELEASE;
  end

  assign wb_en = wb_valid &&
                 !(res_kind == RES_RESTORE &&
                   seq_younger(32'(wb_seq), 32'(res_seq), SW));

  regmap_live #(.NREG(NREG), .DW(DW)) u_live (
    .clk         (clk),
    .rst         (rst),
    .restore_en  (res_kind == RES_RESTORE),
    .restore_val (ck_val[res_slot]),
    .restore_vld (ck_vld[res_slot]),
    .wb_en       (wb_en),
    .wb_reg      (wb_reg),
    .wb_data     (wb_data),
    .claim_en    (ren_valid),
    .claim_reg   (ren_reg),
    .rd_reg      (rd_reg),
    .rd_data     (rd_data),
    .rd_vld      (rd_vld),
    .nxt_val     (nxt_val),
    .nxt_vld     (nxt_vld)
  );

  for (genvar g = 0; g < NCK; g++) begin : g_slot
    logic rel;
    always_comb begin
      rel = 1'b0;
      if (res_kind != RES_IDLE) begin
        if (CW'(g) == res_slot)
          rel = 1'b1;
        else if (res_kind == RES_RESTORE && busy_q[g] &&
                 seq_younger(32'(ck_seq[g]), 32'(res_seq), SW))
          rel = 1'b1;
      end
    end

    regmap_slot #(.NREG(NREG), .DW(DW), .SW(SW)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .alloc      (dec_fire && first_free == CW'(g)),
      .alloc_seq  (dec_seq),
      .cap_val    (nxt_val),
      .cap_vld    (nxt_vld),
      .release_en (rel),
      .wb_en      (wb_en),
      .wb_seq     (wb_seq),
      .wb_reg     (wb_reg),
      .wb_data    (wb_data),
      .busy       (busy_q[g]),
      .seq        (ck_seq[g]),
      .val        (ck_val[g]),
      .vld        (ck_vld[g])
    );
  end

endmodule

// File: rtl/regmap_ckpt_chk.sv
module regmap_ckpt_chk #(
  parameter int NCK = 4,
  localparam int CW = $clog2(NCK)
) (
  input logic           clk,
  input logic           rst,
  input logic           dec_valid,
  input logic           dec_ready,
  input logic [CW-1:0]  dec_slot,
  input logic           res_valid,
  input logic [CW-1:0]  res_slot,
  input logic           res_mispredict,
  input logic [NCK-1:0] busy
);

  assert_reset_free_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy == '0);

  assert_alloc_takes_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_ready) |=> busy[$past(dec_slot)]);

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (&busy || res_valid) |-> !dec_ready);

  assert_restore_frees_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_mispredict && busy[res_slot]) |=> !busy[$past(res_slot)]);

  assert_release_frees_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_mispredict && busy[res_slot]) |=> !busy[$past(res_slot)]);

endmodule

bind regmap_ckpt regmap_ckpt_chk #(.NCK(NCK)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .dec_valid      (dec_valid),
  .dec_ready      (dec_ready),
  .dec_slot       (dec_slot),
  .res_valid      (res_valid),
  .res_slot       (res_slot),
  .res_mispredict (res_mispredict),
  .busy           (busy_q)
);

// File: tb/sim_regmap_ckpt.sv
`timescale 1ns/1ps
module sim_regmap_ckpt;
  localparam int NREG = 8, DW = 16, NCK = 4, SW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic dec_valid = 0, ren_valid = 0, wb_valid = 0, res_valid = 0, res_mispredict = 0;
  logic [SW-1:0] dec_seq = 0, wb_seq = 0;
  logic [2:0] ren_reg = 0, wb_reg = 0, rd_reg = 0;
  logic [15:0] wb_data = 0;
  logic [1:0] res_slot = 0;
  logic dec_ready, rd_vld;
  logic [1:0] dec_slot;
  logic [15:0] rd_data;

  always #5 clk = ~clk;

  regmap_ckpt u0 (.*);

  int checks = 0, errors = 0;

  // bench model, built from the requirements
  logic [15:0] m_val [NREG];
  logic        m_vld [NREG];
  logic [15:0] c_val [NCK][NREG];
  logic        c_vld [NCK][NREG];
  logic [7:0]  c_seq [NCK];
  logic        c_busy[NCK];

  typedef struct { logic [2:0] r; logic [15:0] d; logic v; string tag; } rd_item_t;
  rd_item_t exp_q[$];
  logic rd_pend = 0;

  function automatic logic younger(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] d;
    d = a - b;
    return $signed(d) > 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NCK; i++) if (!c_busy[i]) return i;
    return -1;
  endfunction

  task automatic step(input logic dv, input logic [7:0] ds, input logic rv, input logic [2:0] rr,
                      input logic wv, input logic [7:0] ws, input logic [2:0] wr,
                      input logic [15:0] wd, input logic sv, input logic [1:0] ss,
                      input logic sm, input string tag);
    int fs;
    logic rdy, restore, hit, wen;
    logic [7:0] rseq;
    logic [15:0] nv [NREG];
    logic        nl [NREG];
    @(negedge clk);
    dec_valid = dv; dec_seq = ds; ren_valid = rv; ren_reg = rr;
    wb_valid = wv; wb_seq = ws; wb_reg = wr; wb_data = wd;
    res_valid = sv; res_slot = ss; res_mispredict = sm;
    fs = lowest_free();
    rdy = (fs >= 0) && !sv;
    #1;
    if (dv) begin
      chk({tag, " R7 dec_ready"}, dec_ready, rdy);
      if (rdy) chk({tag, " R4 dec_slot"}, dec_slot, fs);
    end
    @(posedge clk);
    hit = sv && c_busy[ss];
    restore = hit && sm;
    rseq = c_seq[ss];
    wen = wv && !(restore && younger(ws, rseq));
    for (int r = 0; r < NREG; r++) begin
      nv[r] = restore ? c_val[ss][r] : m_val[r];
      nl[r] = restore ? c_vld[ss][r] : m_vld[r];
    end
    if (wen) begin nv[wr] = wd; nl[wr] = 1'b1; end
    if (rv && !restore) nl[rr] = 1'b0;
    for (int i = 0; i < NCK; i++) begin
      if (dv && rdy && i == fs) begin
        c_busy[i] = 1'b1; c_seq[i] = ds;
        for (int r = 0; r < NREG; r++) begin c_val[i][r] = nv[r]; c_vld[i][r] = nl[r]; end
      end else begin
        logic rel;
        rel = hit && (i == ss || (restore && c_busy[i] && younger(c_seq[i], rseq)));
        if (c_busy[i] && wen && younger(c_seq[i], ws)) begin
          c_val[i][wr] = wd; c_vld[i][wr] = 1'b1;
        end
        if (rel) c_busy[i] = 1'b0;
      end
    end
    for (int r = 0; r < NREG; r++) begin m_val[r] = nv[r]; m_vld[r] = nl[r]; end
    @(negedge clk);
    dec_valid = 0; ren_valid = 0; wb_valid = 0; res_valid = 0;
  endtask

  task automatic dec(input logic [7:0] s, input string tag);
    step(1, s, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wb(input logic [7:0] s, input logic [2:0] r, input logic [15:0] d);
    step(0, 0, 0, 0, 1, s, r, d, 0, 0, 0, "wb");
  endtask
  task automatic res(input logic [1:0] sl, input logic mis);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, sl, mis, "res");
  endtask

  // driver: push the expected read result, monitor compares it
  task automatic rd(input logic [2:0] r, input string tag);
    rd_item_t it;
    @(negedge clk);
    rd_reg = r;
    it.r = r; it.d = m_val[r]; it.v = m_vld[r]; it.tag = tag;
    exp_q.push_back(it);
    rd_pend = 1;
    @(posedge clk);
    #3 rd_pend = 0;
  endtask

  always @(posedge clk) begin
    if (rd_pend) begin
      rd_item_t it;
      #1;
      it = exp_q.pop_front();
      chk({it.tag, " data"}, rd_data, it.d);
      chk({it.tag, " ready"}, rd_vld, it.v);
    end
  end

  initial begin
    int wd_hit = 0;
    fork
      begin
        repeat (20000) @(posedge clk);
        wd_hit = 1;
      end
    join_none
    for (int r = 0; r < NREG; r++) begin m_val[r] = 0; m_vld[r] = 1; end
    for (int i = 0; i < NCK; i++) begin
      c_busy[i] = 0; c_seq[i] = 0;
      for (int r = 0; r < NREG; r++) begin c_val[i][r] = 0; c_vld[i][r] = 1; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    chk("R1 dec_ready after reset", dec_ready, 1);
    chk("R1 dec_slot after reset", dec_slot, 0);
    for (int r = 0; r < NREG; r++) rd(r[2:0], "R1 reset map");

    wb(8'd1, 3'd2, 16'h1111);
    rd(3'd2, "R2 writeback");
    step(0, 0, 1, 3'd3, 0, 0, 0, 0, 0, 0, 0, "claim");
    rd(3'd3, "R3 claim");

    dec(8'd10, "R4 first branch");
    wb(8'd5, 3'd4, 16'hAAAA);
    wb(8'd12, 3'd4, 16'hBBBB);
    rd(3'd4, "R2 live younger wb");
    res(2'd0, 1);
    rd(3'd4, "R5 R6 restored");
    rd(3'd3, "R3 claim kept in snapshot");

    dec(8'd20, "R4 fill"); dec(8'd21, "R4 fill");
    dec(8'd22, "R4 fill"); dec(8'd23, "R4 fill");
    dec(8'd24, "R7 full");
    chk("R7 full dec_ready", dec_ready, 0);

    res(2'd1, 1);
    chk("R8 freed younger dec_slot", dec_slot, 1);
    dec(8'd30, "R8 refill"); dec(8'd31, "R8 refill"); dec(8'd32, "R8 refill");
    chk("R8 pool full again", dec_ready, 0);

    wb(8'd33, 3'd1, 16'h5151);
    rd(3'd1, "R9 before release");
    res(2'd0, 0);
    rd(3'd1, "R9 live unchanged");
    chk("R9 slot freed", dec_slot, 0);

    res(2'd1, 0); res(2'd2, 0); res(2'd3, 0);
    dec(8'd40, "R10 setup");
    step(0, 0, 0, 0, 1, 8'd41, 3'd5, 16'h5555, 1, 2'd0, 1, "R10 younger wb");
    rd(3'd5, "R10 younger wb discarded");
    dec(8'd50, "R10 setup");
    step(0, 0, 1, 3'd6, 1, 8'd45, 3'd6, 16'hC6C6, 1, 2'd0, 1, "R10 older wb");
    rd(3'd6, "R10 older wb applied, R3 claim ignored");

    wb(8'd200, 3'd7, 16'h0707);
    dec(8'd250, "R11 near wrap");
    wb(8'd3, 3'd7, 16'h7777);
    wb(8'd240, 3'd0, 16'h0F0F);
    res(2'd0, 1);
    rd(3'd7, "R11 wrapped younger dropped");
    rd(3'd0, "R11 older kept");

    step(1, 8'd60, 0, 0, 1, 8'd59, 3'd2, 16'h2222, 0, 0, 0, "R4 same-cycle capture");
    wb(8'd61, 3'd2, 16'hFFFF);
    res(2'd0, 1);
    rd(3'd2, "R4 snapshot holds same-cycle wb");

    if (wd_hit) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #250000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule